// File: doc/BRIEF.md
# UART receive/transmit buffering stage with flow control

This block sits between the serial shifters of a UART and the parallel port that a host reads and writes. It holds received characters in a receive FIFO whose entries carry the data byte plus three error flags (parity, framing, break). Outgoing characters wait in a byte-wide transmit FIFO until the serial transmitter asks for the next one. Software picks one of three buffering modes: a single holding register, a 16-entry FIFO, or an extended 64-entry FIFO. Both FIFOs are emptied whenever the mode changes.

Flow control works in both directions. With automatic RTS on, the block drops its ready-to-send output once the receive FIFO reaches a mode-dependent mark. With automatic CTS on, no character moves to the transmitter while the far end's clear-to-send is inactive. A receive interrupt fires when the receive fill reaches a selectable trigger level, and a transmit interrupt fires when the transmit FIFO is empty.

A subsystem-side bypass port can replace the serial path. In bypass the subsystem pushes bytes straight into the receive FIFO and pops bytes straight from the transmit FIFO. The interrupt outputs behave exactly as they do on the serial path.

Top module: `ubuf_top`

## Requirements
- R1: Once reset is released the block is in single-register mode with both FIFOs empty, `overrun_o` low, `rts_o` high, `tx_empty_irq_o` high and `rx_irq_o` low.
- R2: `mode_i` selects the capacity of both FIFOs: code 0 gives 1 entry, code 1 gives 16, code 2 or 3 gives 64. A push to a FIFO holding its capacity is dropped. `rx_level_o` and `tx_level_o` report the number of entries held.
- R3: The receive FIFO returns entries in arrival order. `host_rx_data_o` shows the oldest byte and `host_rx_flags_o` shows its flags: bit 2 break, bit 1 framing error, bit 0 parity error. `host_rx_rd_i` removes that entry and has no effect on an empty FIFO.
- R4: A receive push while the receive FIFO holds its capacity sets `overrun_o`, and this applies even if a pop happens in the same cycle. `overrun_o` stays high until a FIFO clear or a mode change.
- R5: With `auto_rts_en_i` high, `rts_o` is low while the receive level is at or above the mark (1 in single mode, 14 in 16-entry mode, 56 in 64-entry mode) and high below it. With `auto_rts_en_i` low, `rts_o` is high.
- R6: `tx_load_o` is high in a cycle exactly when all of these hold: bypass is off, `tx_ready_i` is high, the transmit FIFO is not empty, no clear or mode change is taking place, and either `auto_cts_en_i` is low or `cts_i` is high. In that cycle `tx_data_o` shows the oldest byte and the byte is popped.
- R7: `rx_irq_o` is high while the receive level is at or above the trigger level. `trig_sel_i` values 0/1/2/3 select levels 1/4/8/14 in 16-entry mode and 1/16/32/56 in 64-entry mode. In single mode the level is always 1.
- R8: `tx_empty_irq_o` is high exactly when the transmit FIFO is empty, whether or not bypass is on.
- R9: With `bypass_i` high, `sub_wr_i` pushes `sub_wdata_i` into the receive FIFO with all flags zero, and `sub_rd_i` pops the transmit byte shown on `sub_rdata_o`. In bypass `rx_wr_i` is ignored and `tx_load_o` stays low. With `bypass_i` low, `sub_wr_i` and `sub_rd_i` are ignored.
- R10: A cycle with `fifo_clr_i` high, or with a `mode_i` code that decodes to a mode other than the current one, empties both FIFOs and clears `overrun_o`. All pushes and pops requested in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Buffering mode code (0 single, 1 sixteen, 2/3 sixty-four) |
| fifo_clr_i | input | 1 | Empty both FIFOs |
| trig_sel_i | input | 2 | Receive trigger level select |
| auto_rts_en_i | input | 1 | Enable automatic RTS |
| auto_cts_en_i | input | 1 | Enable CTS gating of transmit |
| bypass_i | input | 1 | Route the subsystem port in place of the serial path |
| cts_i | input | 1 | Clear-to-send from the far end, high = may send |
| rts_o | output | 1 | Ready-to-send to the far end, high = may send |
| rx_wr_i | input | 1 | Receive shifter delivers a character |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error of received byte |
| rx_ferr_i | input | 1 | Framing error of received byte |
| rx_brk_i | input | 1 | Break seen with received byte |
| tx_ready_i | input | 1 | Transmit shifter can take a character |
| tx_load_o | output | 1 | Character handed to the transmit shifter this cycle |
| tx_data_o | output | 8 | Byte handed to the transmit shifter |
| host_rx_rd_i | input | 1 | Host pops the receive FIFO |
| host_rx_data_o | output | 8 | Oldest received byte |
| host_rx_flags_o | output | 3 | Flags of oldest received byte |
| host_tx_wr_i | input | 1 | Host pushes the transmit FIFO |
| host_tx_data_i | input | 8 | Byte to transmit |
| sub_wr_i | input | 1 | Subsystem pushes the receive FIFO (bypass) |
| sub_wdata_i | input | 8 | Subsystem byte for the receive FIFO |
| sub_rd_i | input | 1 | Subsystem pops the transmit FIFO (bypass) |
| sub_rdata_o | output | 8 | Oldest transmit byte for the subsystem |
| rx_level_o | output | 7 | Receive FIFO fill |
| tx_level_o | output | 7 | Transmit FIFO fill |
| rx_irq_o | output | 1 | Receive data at or above trigger level |
| tx_empty_irq_o | output | 1 | Transmit FIFO empty |
| overrun_o | output | 1 | Receive push was dropped |

## Verification
The bench builds the block with its defaults, a 64-entry store with a 16-entry normal capacity. At these values the 14 and 56 RTS marks and the full trigger tables can be hit with a few dozen pushes, and all three capacity limits can be reached. The directed phases saturate each mode, run CTS gating, and drive the serial and bypass strobes at the same time. A long random phase mixes mode changes and clears with simultaneous pushes and pops, so that overrun with a same-cycle pop and flush priority occur many times.

// File: rtl/ubuf_pkg.sv
package ubuf_pkg;

    localparam int UB_DW = 8;

    typedef enum logic [1:0] {
        UB_SINGLE   = 2'd0,
        UB_NORMAL   = 2'd1,
        UB_EXTENDED = 2'd2
    } ub_mode_e;

    typedef struct packed {
        logic             brk;
        logic             ferr;
        logic             perr;
        logic [UB_DW-1:0] data;
    } ub_rx_entry_t;

    function automatic ub_mode_e ub_decode(input logic [1:0] code);
        ub_mode_e m;
        if (code[1])      m = UB_EXTENDED;
        else if (code[0]) m = UB_NORMAL;
        else              m = UB_SINGLE;
        return m;
    endfunction

    function automatic int unsigned ub_size(input ub_mode_e m, input int unsigned deep,
                                            input int unsigned norm);
        int unsigned r;
        case (m)
            UB_NORMAL:   r = norm;
            UB_EXTENDED: r = deep;
            default:     r = 1;
        endcase
        return r;
    endfunction

    function automatic int unsigned ub_rts_mark(input ub_mode_e m, input int unsigned deep,
                                                input int unsigned norm);
        int unsigned r;
        case (m)
            UB_NORMAL:   r = norm - 2;
            UB_EXTENDED: r = deep - 8;
            default:     r = 1;
        endcase
        return r;
    endfunction

    function automatic int unsigned ub_trigger(input ub_mode_e m, input logic [1:0] sel,
                                               input int unsigned deep, input int unsigned norm);
        int unsigned r;
        int unsigned sz;
        sz = ub_size(m, deep, norm);
        if (m == UB_SINGLE) r = 1;
        else begin
            case (sel)
                2'd0:    r = 1;
                2'd1:    r = sz / 4;
                2'd2:    r = sz / 2;
                default: r = ub_rts_mark(m, deep, norm);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ubuf_fifo.sv
module ubuf_fifo #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [CW-1:0]    cap_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [CW-1:0]    count_o,
    output logic             drop_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push_i && (cnt_q < cap_i);
    assign pop_ok  = pop_i && (cnt_q != '0);
    assign drop_o  = push_i && !(cnt_q < cap_i);
    assign dout_o  = mem[rd_q];
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush_i && !rst) mem[wr_q] <= din_i;
    end

endmodule

// File: rtl/ubuf_flow.sv
module ubuf_flow
    import ubuf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int NORM_DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  ub_mode_e      mode_i,
    input  logic [1:0]    trig_sel_i,
    input  logic          auto_rts_en_i,
    input  logic [CW-1:0] rx_count_i,
    input  logic [CW-1:0] tx_count_i,
    output logic [CW-1:0] cap_o,
    output logic          rts_o,
    output logic          rx_irq_o,
    output logic          tx_empty_o
);

    logic [CW-1:0] mark, trig;

    assign cap_o = CW'(ub_size(mode_i, DEPTH, NORM_DEPTH));
    assign mark  = CW'(ub_rts_mark(mode_i, DEPTH, NORM_DEPTH));
    assign trig  = CW'(ub_trigger(mode_i, trig_sel_i, DEPTH, NORM_DEPTH));

    assign rts_o      = !auto_rts_en_i || (rx_count_i < mark);
    assign rx_irq_o   = (rx_count_i >= trig);
    assign tx_empty_o = (tx_count_i == '0);

endmodule

// File: rtl/ubuf_top.sv
module ubuf_top
    import ubuf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int NORM_DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int RXW = $bits(ub_rx_entry_t)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             fifo_clr_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             auto_rts_en_i,
    input  logic             auto_cts_en_i,
    input  logic             bypass_i,
    input  logic             cts_i,
    output logic             rts_o,
    input  logic             rx_wr_i,
    input  logic [UB_DW-1:0] rx_data_i,
    input  logic             rx_perr_i,
    input  logic             rx_ferr_i,
    input  logic             rx_brk_i,
    input  logic             tx_ready_i,
    output logic             tx_load_o,
    output logic [UB_DW-1:0] tx_data_o,
    input  logic             host_rx_rd_i,
    output logic [UB_DW-1:0] host_rx_data_o,
    output logic [2:0]       host_rx_flags_o,
    input  logic             host_tx_wr_i,
    input  logic [UB_DW-1:0] host_tx_data_i,
    input  logic             sub_wr_i,
    input  logic [UB_DW-1:0] sub_wdata_i,
    input  logic             sub_rd_i,
    output logic [UB_DW-1:0] sub_rdata_o,
    output logic [CW-1:0]    rx_level_o,
    output logic [CW-1:0]    tx_level_o,
    output logic             rx_irq_o,
    output logic             tx_empty_irq_o,
    output logic             overrun_o
);

    ub_mode_e     mode_q, mode_new;
    logic         flush, ovr_q;
    logic [CW-1:0] cap;
    ub_rx_entry_t rx_in, rx_head;
    logic [RXW-1:0] rx_dout;
    logic         rx_push, rx_drop, tx_pop, tx_drop;
    logic [UB_DW-1:0] tx_head;

    assign mode_new = ub_decode(mode_i);
    assign flush    = fifo_clr_i || (mode_new != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= UB_SINGLE;
        else     mode_q <= mode_new;
    end

    // Receive source: subsystem port in bypass, serial shifter otherwise
    always_comb begin
        if (bypass_i) begin
            rx_push = sub_wr_i;
            rx_in   = '{brk: 1'b0, ferr: 1'b0, perr: 1'b0, data: sub_wdata_i};
        end else begin
            rx_push = rx_wr_i;
            rx_in   = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};
        end
    end

    assign tx_load_o = !bypass_i && !flush && tx_ready_i && (tx_level_o != '0)
                       && (!auto_cts_en_i || cts_i);
    assign tx_pop    = bypass_i ? sub_rd_i : tx_load_o;

    ubuf_flow #(.DEPTH(DEPTH), .NORM_DEPTH(NORM_DEPTH)) u_flow (
        .mode_i        (mode_q),
        .trig_sel_i    (trig_sel_i),
        .auto_rts_en_i (auto_rts_en_i),
        .rx_count_i    (rx_level_o),
        .tx_count_i    (tx_level_o),
        .cap_o         (cap),
        .rts_o         (rts_o),
        .rx_irq_o      (rx_irq_o),
        .tx_empty_o    (tx_empty_irq_o)
    );

    ubuf_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush),
        .cap_i   (cap),
        .push_i  (rx_push),
        .din_i   (rx_in),
        .pop_i   (host_rx_rd_i),
        .dout_o  (rx_dout),
        .count_o (rx_level_o),
        .drop_o  (rx_drop)
    );

    ubuf_fifo #(.WIDTH(UB_DW), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush),
        .cap_i   (cap),
        .push_i  (host_tx_wr_i),
        .din_i   (host_tx_data_i),
        .pop_i   (tx_pop),
        .dout_o  (tx_head),
        .count_o (tx_level_o),
        .drop_o  (tx_drop)
    );

    assign rx_head         = ub_rx_entry_t'(rx_dout);
    assign host_rx_data_o  = rx_head.data;
    assign host_rx_flags_o = {rx_head.brk, rx_head.ferr, rx_head.perr};
    assign tx_data_o       = tx_head;
    assign sub_rdata_o     = tx_head;

    // Transmit overflow is silent; only the receive side reports loss
    always_ff @(posedge clk) begin
        if (rst || flush)   ovr_q <= 1'b0;
        else if (rx_drop)   ovr_q <= 1'b1;
        else if (tx_drop)   ovr_q <= ovr_q;
    end
    assign overrun_o = ovr_q;

endmodule

// File: rtl/ubuf_chk.sv
module ubuf_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_clr_i,
    input logic          auto_rts_en_i,
    input logic          auto_cts_en_i,
    input logic          bypass_i,
    input logic          cts_i,
    input logic          rts_o,
    input logic          rx_wr_i,
    input logic          sub_wr_i,
    input logic          tx_ready_i,
    input logic          tx_load_o,
    input logic [CW-1:0] rx_level_o,
    input logic [CW-1:0] tx_level_o,
    input logic          tx_empty_irq_o,
    input logic          overrun_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rx_level_o == '0 && tx_level_o == '0 && rts_o && tx_empty_irq_o && !overrun_o));

    // R4
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> ($past(rx_level_o) != '0 && ($past(rx_wr_i) || $past(sub_wr_i))));

    // R5
    rts_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_rts_en_i || rx_level_o == '0) |-> rts_o);

    // R6
    load_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load_o |-> (tx_ready_i && tx_level_o != '0 && (!auto_cts_en_i || cts_i)));

    // R8
    tx_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty_irq_o |-> tx_level_o == '0);

    // R8
    tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_empty_irq_o |-> tx_level_o != '0);

    // R9
    bypass_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_i |-> !tx_load_o);

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr_i |=> (rx_level_o == '0 && tx_level_o == '0 && !overrun_o));

endmodule

bind ubuf_top ubuf_chk #(.CW(CW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fifo_clr_i     (fifo_clr_i),
    .auto_rts_en_i  (auto_rts_en_i),
    .auto_cts_en_i  (auto_cts_en_i),
    .bypass_i       (bypass_i),
    .cts_i          (cts_i),
    .rts_o          (rts_o),
    .rx_wr_i        (rx_wr_i),
    .sub_wr_i       (sub_wr_i),
    .tx_ready_i     (tx_ready_i),
    .tx_load_o      (tx_load_o),
    .rx_level_o     (rx_level_o),
    .tx_level_o     (tx_level_o),
    .tx_empty_irq_o (tx_empty_irq_o),
    .overrun_o      (overrun_o)
);

// File: tb/sim_ubuf_top.sv
`timescale 1ns/1ps
module sim_ubuf_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic fifo_clr_i = 0, auto_rts_en_i = 0, auto_cts_en_i = 0, bypass_i = 0, cts_i = 0;
    logic [1:0] trig_sel_i = 2'd0;
    logic rx_wr_i = 0, rx_perr_i = 0, rx_ferr_i = 0, rx_brk_i = 0, tx_ready_i = 0;
    logic [7:0] rx_data_i = 0, host_tx_data_i = 0, sub_wdata_i = 0;
    logic host_rx_rd_i = 0, host_tx_wr_i = 0, sub_wr_i = 0, sub_rd_i = 0;
    logic rts_o, tx_load_o, rx_irq_o, tx_empty_irq_o, overrun_o;
    logic [7:0] tx_data_o, host_rx_data_o, sub_rdata_o;
    logic [2:0] host_rx_flags_o;
    logic [6:0] rx_level_o, tx_level_o;

    always #4 clk = ~clk;

    ubuf_top u0 (.*);

    int total = 0;
    int bad = 0;
    int rxq[$];
    int txq[$];
    int mode_m = 0;
    bit ovr_m = 0;

    function automatic int dec(input logic [1:0] c);
        return c[1] ? 2 : (c[0] ? 1 : 0);
    endfunction
    function automatic int cap_m();
        return (mode_m == 0) ? 1 : ((mode_m == 1) ? 16 : 64);
    endfunction
    function automatic int mark_m();
        return (mode_m == 0) ? 1 : ((mode_m == 1) ? 14 : 56);
    endfunction
    function automatic int trig_m();
        int n1[4] = '{1, 4, 8, 14};
        int n2[4] = '{1, 16, 32, 56};
        if (mode_m == 0) return 1;
        return (mode_m == 1) ? n1[trig_sel_i] : n2[trig_sel_i];
    endfunction
    function automatic bit flush_m();
        return fifo_clr_i || (dec(mode_i) != mode_m);
    endfunction
    function automatic bit load_m();
        return !bypass_i && !flush_m() && tx_ready_i && (txq.size() > 0)
               && (!auto_cts_en_i || cts_i);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 rx_level", rx_level_o, rxq.size());
        chk("R2 tx_level", tx_level_o, txq.size());
        chk("R4 overrun", overrun_o, ovr_m);
        chk("R5 rts", rts_o, (!auto_rts_en_i || rxq.size() < mark_m()) ? 1 : 0);
        chk("R7 rx_irq", rx_irq_o, (rxq.size() >= trig_m()) ? 1 : 0);
        chk("R8 tx_empty", tx_empty_irq_o, (txq.size() == 0) ? 1 : 0);
        chk("R6 tx_load", tx_load_o, load_m());
        if (rxq.size() > 0) begin
            chk("R3 rx_data", host_rx_data_o, rxq[0] & 255);
            chk("R3 rx_flags", host_rx_flags_o, rxq[0] >> 8);
        end
        if (txq.size() > 0) begin
            chk("R6 tx_data", tx_data_o, txq[0]);
            chk("R9 sub_rdata", sub_rdata_o, txq[0]);
        end
    endtask

    task automatic update();
        int rsz, tsz, ent;
        bit rpush, rpop, tpop;
        if (flush_m()) begin
            rxq.delete();
            txq.delete();
            ovr_m  = 0;
            mode_m = dec(mode_i);
            return;
        end
        rsz   = rxq.size();
        tsz   = txq.size();
        rpush = bypass_i ? sub_wr_i : rx_wr_i;
        ent   = bypass_i ? int'(sub_wdata_i)
                         : int'({rx_brk_i, rx_ferr_i, rx_perr_i, rx_data_i});
        rpop  = host_rx_rd_i && rsz > 0;
        tpop  = bypass_i ? (sub_rd_i && tsz > 0) : load_m();
        if (rpop) void'(rxq.pop_front());
        if (rpush) begin
            if (rsz < cap_m()) rxq.push_back(ent);
            else ovr_m = 1;
        end
        if (tpop) void'(txq.pop_front());
        if (host_tx_wr_i && tsz < cap_m()) txq.push_back(int'(host_tx_data_i));
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        @(posedge clk);
        update();
        #1;
    endtask

    task automatic quiet();
        rx_wr_i = 0; host_rx_rd_i = 0; host_tx_wr_i = 0; sub_wr_i = 0; sub_rd_i = 0;
        tx_ready_i = 0; fifo_clr_i = 0;
        rx_perr_i = 0; rx_ferr_i = 0; rx_brk_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_level", rx_level_o, 0);
        chk("R1 tx_level", tx_level_o, 0);
        chk("R1 rts", rts_o, 1);
        chk("R1 tx_empty", tx_empty_irq_o, 1);
        chk("R1 rx_irq", rx_irq_o, 0);
        chk("R1 overrun", overrun_o, 0);
        @(posedge clk); #1;

        // Single-register mode: second push overruns, RTS drops at one
        auto_rts_en_i = 1;
        rx_wr_i = 1; rx_data_i = 8'h41; rx_brk_i = 1; cycle();
        rx_brk_i = 0; rx_data_i = 8'h42; cycle();
        quiet(); cycle();
        host_rx_rd_i = 1; cycle();
        cycle();
        quiet(); cycle();

        // 16-entry mode: saturate with flagged data, sweep triggers
        mode_i = 2'd1; cycle();
        for (int i = 0; i < 20; i++) begin
            rx_wr_i = 1; rx_data_i = 8'(i + 16);
            {rx_brk_i, rx_ferr_i, rx_perr_i} = 3'(i);
            trig_sel_i = 2'(i);
            cycle();
        end
        quiet();
        for (int i = 0; i < 6; i++) begin
            host_rx_rd_i = 1; trig_sel_i = 2'(i); cycle();
        end
        quiet();
        fifo_clr_i = 1; cycle();
        fifo_clr_i = 0;
        @(negedge clk);
        chk("R10 clear rx", rx_level_o, 0);
        chk("R10 clear overrun", overrun_o, 0);
        @(posedge clk); #1;

        // Transmit with CTS gating
        for (int i = 0; i < 6; i++) begin
            host_tx_wr_i = 1; host_tx_data_i = 8'(8'h80 + i); cycle();
        end
        quiet();
        auto_cts_en_i = 1; cts_i = 0; tx_ready_i = 1;
        repeat (3) cycle();
        cts_i = 1; repeat (2) cycle();
        auto_cts_en_i = 0; cts_i = 0; repeat (5) cycle();
        quiet();

        // 64-entry mode: RTS mark 56, trigger table, full overrun
        mode_i = 2'd2; cycle();
        for (int i = 0; i < 70; i++) begin
            rx_wr_i = 1; rx_data_i = 8'(i); trig_sel_i = 2'(i >> 2); cycle();
        end
        rx_wr_i = 1; host_rx_rd_i = 1; cycle();
        quiet();
        for (int i = 0; i < 20; i++) begin
            host_rx_rd_i = 1; trig_sel_i = 2'(i); cycle();
        end
        quiet();
        mode_i = 2'd3; repeat (2) cycle();
        mode_i = 2'd1; cycle();

        // Bypass: subsystem port replaces serial path
        bypass_i = 1;
        for (int i = 0; i < 4; i++) begin
            host_tx_wr_i = 1; host_tx_data_i = 8'(8'hA0 + i); cycle();
        end
        quiet();
        tx_ready_i = 1; rx_wr_i = 1; rx_data_i = 8'hEE; rx_perr_i = 1;
        sub_wr_i = 1; sub_wdata_i = 8'h5A; cycle();
        sub_wr_i = 0; cycle();
        @(negedge clk);
        // R9 serial receive ignored in bypass
        chk("R9 serial ignored", rx_level_o, 1);
        @(posedge clk); #1;
        quiet(); tx_ready_i = 1;
        sub_rd_i = 1; repeat (2) cycle();
        quiet();
        bypass_i = 0; sub_wr_i = 1; sub_rd_i = 1; repeat (2) cycle();
        quiet(); cycle();

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(63) == 0) mode_i = 2'($urandom);
            fifo_clr_i    = ($urandom_range(127) == 0);
            bypass_i      = ($urandom_range(7) == 0) ? ~bypass_i : bypass_i;
            auto_rts_en_i = ($urandom_range(31) == 0) ? ~auto_rts_en_i : auto_rts_en_i;
            auto_cts_en_i = ($urandom_range(31) == 0) ? ~auto_cts_en_i : auto_cts_en_i;
            cts_i         = $urandom_range(3) != 0;
            trig_sel_i    = 2'($urandom);
            rx_wr_i       = $urandom_range(2) != 0;
            rx_data_i     = 8'($urandom);
            {rx_brk_i, rx_ferr_i, rx_perr_i} = 3'($urandom);
            sub_wr_i      = $urandom_range(2) != 0;
            sub_wdata_i   = 8'($urandom);
            host_rx_rd_i  = $urandom_range(2) == 0;
            host_tx_wr_i  = $urandom_range(2) != 0;
            host_tx_data_i = 8'($urandom);
            tx_ready_i    = $urandom_range(2) == 0;
            sub_rd_i      = $urandom_range(2) == 0;
            cycle();
        end
        quiet();
        cycle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule